// File: doc/BRIEF.md
# DMA Dispatcher Control and Status Register Block

This block is the software-facing register file of a descriptor-driven DMA dispatcher. It shows the live state of the descriptor queue, the response queue and the transfer engine. It holds a small control word that can stop dispatch, stop descriptor fetch and arm automatic stops. It latches completion, error and early-termination events into sticky status bits, which software clears by writing 1 to them. Those sticky bits drive one interrupt line, and a global enable gates that line.

Software starts a controller reset by writing the reset control bit. The block then runs a timed sequence of `RST_CYCLES` clock cycles. During the sequence the resetting flag is visible in status, and the engine reset output stays high. When the sequence ends, the control word and the sticky bits return to zero and the queues receive a one-cycle flush pulse. Reads are combinational on a 32-bit word-aligned bus. Writes take effect at the clock edge that samples them.

Top module: `dma_csr_regs`

## Requirements
- R1: Register reads use word index `bus_addr[4:2]`, and any index above 4 reads zero. Index 2 returns the write-side queue level in bits 31:16 and the read-side level in bits 15:0. Index 3 returns the response queue level in bits 15:0. Index 4 returns the write sequence number in bits 31:16 and the read sequence number in bits 15:0.
- R2: The status register at index 0 has these bits: 0 engine busy, 1 descriptor queue empty, 2 descriptor queue full, 3 response queue empty, 4 response queue full, 5 stopped, 6 resetting, 7 stopped on error, 8 stopped on early end, 9 interrupt pending. Bits 0 to 4 follow their inputs directly, and writes do not change them.
- R3: The control register is at index 1. Bit 0 is stop, bit 1 is reset, bit 2 is stop on error, bit 3 is stop on early end, bit 4 is global interrupt enable and bit 5 is fetch stop. The register reads back what was written, except bit 1. Bit 0 sets status bit 5 and `dispatch_halt`, and bit 5 drives `fetch_halt`.
- R4: A completion pulse sets interrupt pending only when `done_irq_en` is high in the same cycle.
- R5: An error pulse sets interrupt pending only when `err_code & err_irq_mask` is nonzero. An early-end pulse sets it only when `early_irq_en` is high.
- R6: The `irq` output is high exactly while interrupt pending and control bit 4 are both 1.
- R7: Writing 1 to status bit 7, 8 or 9 clears that bit, and writing 0 leaves it unchanged. If an event sets a bit in the same cycle that a write clears it, the set takes priority.
- R8: An error pulse while control bit 2 is set raises status bits 7 and 5 and `dispatch_halt`. They stay up until software clears bit 7.
- R9: An early-end pulse while control bit 3 is set raises status bits 8 and 5 and `dispatch_halt`. They stay up until software clears bit 8.
- R10: A control write with bit 1 set starts the reset sequence. The resetting state begins the cycle after the write and lasts exactly `RST_CYCLES` cycles. During it, status bit 6, control readback bit 1, `eng_reset` and `dispatch_halt` are all high, and control writes are ignored.
- R11: When the reset sequence ends, the control register and status bits 7 to 9 read zero. `fifo_flush` is high for one cycle, in the first cycle after resetting falls.
- R12: Completion, error and early-end pulses that arrive during the reset sequence have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Byte address (word index in bits 4:2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| eng_busy | input | 1 | Transfer engine busy |
| dq_empty | input | 1 | Descriptor queue empty |
| dq_full | input | 1 | Descriptor queue full |
| rq_empty | input | 1 | Response queue empty |
| rq_full | input | 1 | Response queue full |
| dq_wr_level | input | LVL_W | Write-side descriptor queue level |
| dq_rd_level | input | LVL_W | Read-side descriptor queue level |
| rq_level | input | LVL_W | Response queue level |
| wr_seq | input | SEQ_W | Write-side sequence number |
| rd_seq | input | SEQ_W | Read-side sequence number |
| done_evt | input | 1 | Descriptor completion pulse |
| done_irq_en | input | 1 | Completion interrupt flag of that descriptor |
| err_evt | input | 1 | Error pulse |
| err_code | input | 8 | Error code of that transfer |
| err_irq_mask | input | 8 | Error interrupt mask of that descriptor |
| early_evt | input | 1 | Early-termination pulse |
| early_irq_en | input | 1 | Early interrupt flag of that descriptor |
| dispatch_halt | output | 1 | Stop dispatching descriptors |
| fetch_halt | output | 1 | Stop fetching descriptors |
| eng_reset | output | 1 | Engine reset, high during the sequence |
| fifo_flush | output | 1 | One-cycle queue flush pulse |
| irq | output | 1 | Interrupt request |

## Verification
Several patterns drive the interrupt path, and each one separates a different condition. Completions are sent both with and without their descriptor flag. Errors are sent with a mask that misses the error code and with one that overlaps it, which shows the mask acts as a bitwise match rather than as a plain flag. The automatic stops are tried both with their control bit armed and with it clear, so a stop that fires unconditionally would be caught. The reset sequence is timed cycle by cycle to catch an off-by-one in its length, and it is given events during the sequence to show that they are ignored. Writes of all ones to the live status bits and writes of zero to the sticky bits check that only the three clearable bits respond to writes.

// File: rtl/dcsr_pkg.sv
package dcsr_pkg;
  // word indices of the register window
  localparam int unsigned IDX_STAT  = 0;
  localparam int unsigned IDX_CTL   = 1;
  localparam int unsigned IDX_LVL   = 2;
  localparam int unsigned IDX_RLVL  = 3;
  localparam int unsigned IDX_SEQ   = 4;
  // control bit positions
  localparam int unsigned C_STOP    = 0;
  localparam int unsigned C_RST     = 1;
  localparam int unsigned C_SOE     = 2;
  localparam int unsigned C_SOL     = 3;
  localparam int unsigned C_GIE     = 4;
  localparam int unsigned C_NOFETCH = 5;
  localparam int unsigned CTL_W     = 6;
  // clearable status bit positions
  localparam int unsigned S_STERR   = 7;
  localparam int unsigned S_STEARLY = 8;
  localparam int unsigned S_IRQ     = 9;

  typedef struct packed {
    logic irq_pend;
    logic st_early;
    logic st_err;
    logic resetting;
    logic stopped;
    logic rq_full;
    logic rq_empty;
    logic dq_full;
    logic dq_empty;
    logic busy;
  } stat_t;

  function automatic logic [31:0] pack_halves(input logic [15:0] hi, input logic [15:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic code_hits(input logic [7:0] code, input logic [7:0] mask);
    return |(code & mask);
  endfunction

  function automatic logic [31:0] pack_status(input stat_t s);
    return {22'd0, s};
  endfunction
endpackage

// File: rtl/dcsr_reset_seq.sv
module dcsr_reset_seq #(
  parameter int unsigned RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic last,
  output logic flush
);
  localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  assign active = (cnt_q != '0);
  assign last   = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flush <= 1'b0;
    end else begin
      flush <= last;
      if (active)     cnt_q <= cnt_q - CNT_W'(1);
      else if (start) cnt_q <= CNT_W'(RST_CYCLES);
    end
  end
endmodule

// File: rtl/dcsr_events.sv
module dcsr_events (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_all,
  input  logic done_set,
  input  logic err_evt,
  input  logic err_irq,
  input  logic early_evt,
  input  logic early_irq,
  input  logic arm_err,
  input  logic arm_early,
  input  logic w1c_err,
  input  logic w1c_early,
  input  logic w1c_irq,
  output logic st_err,
  output logic st_early,
  output logic irq_pend,
  output logic irq_set
);
  logic err_stop_set, early_stop_set;

  assign irq_set        = done_set | (err_evt & err_irq) | (early_evt & early_irq);
  assign err_stop_set   = err_evt & arm_err;
  assign early_stop_set = early_evt & arm_early;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_err   <= 1'b0;
      st_early <= 1'b0;
      irq_pend <= 1'b0;
    end else if (clr_all) begin
      st_err   <= 1'b0;
      st_early <= 1'b0;
      irq_pend <= 1'b0;
    end else begin
      st_err   <= err_stop_set   | (st_err   & ~w1c_err);
      st_early <= early_stop_set | (st_early & ~w1c_early);
      irq_pend <= irq_set        | (irq_pend & ~w1c_irq);
    end
  end
endmodule

// File: rtl/dma_csr_regs.sv
module dma_csr_regs
  import dcsr_pkg::*;
#(
  parameter int unsigned LVL_W      = 16,
  parameter int unsigned SEQ_W      = 16,
  parameter int unsigned RST_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [4:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             eng_busy,
  input  logic             dq_empty,
  input  logic             dq_full,
  input  logic             rq_empty,
  input  logic             rq_full,
  input  logic [LVL_W-1:0] dq_wr_level,
  input  logic [LVL_W-1:0] dq_rd_level,
  input  logic [LVL_W-1:0] rq_level,
  input  logic [SEQ_W-1:0] wr_seq,
  input  logic [SEQ_W-1:0] rd_seq,
  input  logic             done_evt,
  input  logic             done_irq_en,
  input  logic             err_evt,
  input  logic [7:0]       err_code,
  input  logic [7:0]       err_irq_mask,
  input  logic             early_evt,
  input  logic             early_irq_en,
  output logic             dispatch_halt,
  output logic             fetch_halt,
  output logic             eng_reset,
  output logic             fifo_flush,
  output logic             irq
);
  localparam int unsigned IDX_W = 3;

  logic [IDX_W-1:0] idx;
  logic             wr_stat, wr_ctl;
  logic [CTL_W-1:0] ctl_q;
  logic             rst_active, rst_last, rst_start;
  logic             st_err, st_early, irq_pend, irq_set;
  logic             stopped;
  stat_t            stat;

  assign idx       = bus_addr[4:2];
  assign wr_stat   = bus_wr && (idx == IDX_W'(IDX_STAT));
  assign wr_ctl    = bus_wr && (idx == IDX_W'(IDX_CTL)) && !rst_active;
  assign rst_start = wr_ctl && bus_wdata[C_RST];

  dcsr_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .start (rst_start),
    .active(rst_active),
    .last  (rst_last),
    .flush (fifo_flush)
  );

  dcsr_events u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_all  (rst_last),
    .done_set (done_evt & done_irq_en & ~rst_active),
    .err_evt  (err_evt & ~rst_active),
    .err_irq  (code_hits(err_code, err_irq_mask)),
    .early_evt(early_evt & ~rst_active),
    .early_irq(early_irq_en),
    .arm_err  (ctl_q[C_SOE]),
    .arm_early(ctl_q[C_SOL]),
    .w1c_err  (wr_stat & bus_wdata[S_STERR]),
    .w1c_early(wr_stat & bus_wdata[S_STEARLY]),
    .w1c_irq  (wr_stat & bus_wdata[S_IRQ]),
    .st_err   (st_err),
    .st_early (st_early),
    .irq_pend (irq_pend),
    .irq_set  (irq_set)
  );

  // control word; the reset bit is never stored, it reads the live sequence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (rst_last) begin
      ctl_q <= '0;
    end else if (wr_ctl) begin
      ctl_q          <= bus_wdata[CTL_W-1:0];
      ctl_q[C_RST]   <= 1'b0;
    end
  end

  assign stopped       = ctl_q[C_STOP] | st_err | st_early;
  assign dispatch_halt = stopped | rst_active;
  assign fetch_halt    = ctl_q[C_NOFETCH];
  assign eng_reset     = rst_active;
  assign irq           = irq_pend & ctl_q[C_GIE];

  always_comb begin
    stat.irq_pend  = irq_pend;
    stat.st_early  = st_early;
    stat.st_err    = st_err;
    stat.resetting = rst_active;
    stat.stopped   = stopped;
    stat.rq_full   = rq_full;
    stat.rq_empty  = rq_empty;
    stat.dq_full   = dq_full;
    stat.dq_empty  = dq_empty;
    stat.busy      = eng_busy;
  end

  always_comb begin
    unique case (idx)
      IDX_W'(IDX_STAT): bus_rdata = pack_status(stat);
      IDX_W'(IDX_CTL):  bus_rdata = {{(32-CTL_W){1'b0}},
                                     ctl_q | (CTL_W'(rst_active) << C_RST)};
      IDX_W'(IDX_LVL):  bus_rdata = pack_halves(16'(dq_wr_level), 16'(dq_rd_level));
      IDX_W'(IDX_RLVL): bus_rdata = {16'd0, 16'(rq_level)};
      IDX_W'(IDX_SEQ):  bus_rdata = pack_halves(16'(wr_seq), 16'(rd_seq));
      default:          bus_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/dcsr_checker.sv
module dcsr_checker #(
  parameter int unsigned RST_CYCLES = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic [4:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic       err_evt,
  input logic       arm_err,
  input logic       st_err,
  input logic       dispatch_halt,
  input logic       eng_reset,
  input logic       fifo_flush,
  input logic       irq_pend,
  input logic       irq_set
);
  localparam int unsigned RW = $clog2(RST_CYCLES + 2);
  logic [RW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_len <= '0;
    else if (!eng_reset) run_len <= '0;
    else                 run_len <= run_len + RW'(1);
  end

  // R10
  rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_reset |-> (run_len < RW'(RST_CYCLES)));

  // R11
  flush_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eng_reset) |-> fifo_flush);

  // R8
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && arm_err && !eng_reset) |=> (st_err && dispatch_halt));

  // R4
  pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend) |-> $past(irq_set));

  // R7
  w1c_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[4:2] == 3'd0 && bus_wdata[9] && !irq_set) |=> !irq_pend);

  // R12
  quiet_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_reset |=> !$rose(irq_pend));
endmodule

bind dma_csr_regs dcsr_checker #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .err_evt      (err_evt),
  .arm_err      (ctl_q[2]),
  .st_err       (st_err),
  .dispatch_halt(dispatch_halt),
  .eng_reset    (eng_reset),
  .fifo_flush   (fifo_flush),
  .irq_pend     (irq_pend),
  .irq_set      (irq_set)
);

// File: tb/dma_csr_regs_bench.sv
`timescale 1ns/1ps
module dma_csr_regs_bench;
  localparam int unsigned RSTC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic eng_busy = 0, dq_empty = 1, dq_full = 0, rq_empty = 1, rq_full = 0;
  logic [15:0] dq_wr_level = '0, dq_rd_level = '0, rq_level = '0, wr_seq = '0, rd_seq = '0;
  logic done_evt = 0, done_irq_en = 0, err_evt = 0, early_evt = 0, early_irq_en = 0;
  logic [7:0] err_code = '0, err_irq_mask = '0;
  logic dispatch_halt, fetch_halt, eng_reset, fifo_flush, irq;

  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  dma_csr_regs #(.LVL_W(16), .SEQ_W(16), .RST_CYCLES(RSTC)) u_dma_csr_regs (
    .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .eng_busy, .dq_empty, .dq_full, .rq_empty, .rq_full,
    .dq_wr_level, .dq_rd_level, .rq_level, .wr_seq, .rd_seq,
    .done_evt, .done_irq_en, .err_evt, .err_code, .err_irq_mask,
    .early_evt, .early_irq_en,
    .dispatch_halt, .fetch_halt, .eng_reset, .fifo_flush, .irq
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'(idx << 2); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    bus_addr = 5'(idx << 2);
    #0.5;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic dn, input logic er, input logic ea);
    @(negedge clk);
    done_evt = dn; err_evt = er; early_evt = ea;
    @(negedge clk);
    done_evt = 0; err_evt = 0; early_evt = 0;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    rd(0, v); check("R2 reset status", v, 32'h0000000A);
    rd(1, v); check("R3 reset control", v, 32'h0);
    check("R6 reset irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_readmap();
    logic [31:0] v;
    dq_wr_level = 16'h1234; dq_rd_level = 16'h0056; rq_level = 16'h00A7;
    wr_seq = 16'hBEEF; rd_seq = 16'h0102;
    rd(2, v); check("R1 levels", v, 32'h12340056);
    rd(3, v); check("R1 resp level", v, 32'h000000A7);
    rd(4, v); check("R1 seq", v, 32'hBEEF0102);
    rd(6, v); check("R1 unused", v, 32'h0);
  endtask

  task automatic t_live_bits();
    logic [31:0] v;
    eng_busy = 1; dq_empty = 0; dq_full = 1; rq_empty = 1; rq_full = 0;
    wr(0, 32'h0000007F);
    rd(0, v); check("R2 live ignore write", v, 32'h0000000D);
    eng_busy = 0; dq_empty = 1; dq_full = 0;
    rd(0, v); check("R2 live follow", v, 32'h0000000A);
  endtask

  task automatic t_done_irq();
    logic [31:0] v;
    done_irq_en = 0; pulse(1, 0, 0);
    rd(0, v); check("R4 done no flag", v & 32'h200, 32'h0);
    done_irq_en = 1; pulse(1, 0, 0); done_irq_en = 0;
    rd(0, v); check("R4 done flag", v & 32'h200, 32'h200);
    check("R6 irq gated off", {31'd0, irq}, 32'd0);
    wr(1, 32'h10);
    check("R6 irq enabled", {31'd0, irq}, 32'd1);
    wr(0, 32'h0);
    rd(0, v); check("R7 write zero keeps", v & 32'h200, 32'h200);
    wr(0, 32'h200);
    rd(0, v); check("R7 w1c irq", v & 32'h200, 32'h0);
    check("R6 irq drops", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_err_mask();
    logic [31:0] v;
    err_code = 8'h04; err_irq_mask = 8'h02; pulse(0, 1, 0);
    rd(0, v); check("R5 err mask miss", v & 32'h3A0, 32'h0);
    err_irq_mask = 8'h06; pulse(0, 1, 0);
    rd(0, v); check("R5 err mask hit", v & 32'h3A0, 32'h200);
    wr(0, 32'h200);
    early_irq_en = 1; pulse(0, 0, 1); early_irq_en = 0;
    rd(0, v); check("R5 early flag", v & 32'h3A0, 32'h200);
    wr(0, 32'h200);
  endtask

  task automatic t_stop_err();
    logic [31:0] v;
    err_irq_mask = 8'h00;
    wr(1, 32'h04); pulse(0, 1, 0);
    rd(0, v); check("R8 stopped on error", v, 32'h000000AA);
    check("R8 halt", {31'd0, dispatch_halt}, 32'd1);
    wr(0, 32'h080);
    rd(0, v); check("R8 cleared", v, 32'h0000000A);
    check("R8 halt released", {31'd0, dispatch_halt}, 32'd0);
    wr(1, 32'h00); pulse(0, 1, 0);
    rd(0, v); check("R8 not armed", v, 32'h0000000A);
  endtask

  task automatic t_stop_early();
    logic [31:0] v;
    wr(1, 32'h08); pulse(0, 0, 1);
    rd(0, v); check("R9 stopped on early", v, 32'h0000012A);
    check("R9 halt", {31'd0, dispatch_halt}, 32'd1);
    wr(0, 32'h100);
    rd(0, v); check("R9 cleared", v, 32'h0000000A);
  endtask

  task automatic t_ctl_bits();
    logic [31:0] v;
    wr(1, 32'h21);
    rd(1, v); check("R3 ctl readback", v, 32'h21);
    rd(0, v); check("R3 stop status", v & 32'h20, 32'h20);
    check("R3 halt+fetch", {30'd0, dispatch_halt, fetch_halt}, 32'd3);
    wr(1, 32'h0);
    check("R3 released", {30'd0, dispatch_halt, fetch_halt}, 32'd0);
  endtask

  task automatic t_reset_seq();
    logic [31:0] v;
    done_irq_en = 1; pulse(1, 0, 0); done_irq_en = 0;
    wr(1, 32'h3E);
    rd(1, v); check("R10 ctl bit1 during reset", v & 32'h2, 32'h2);
    rd(0, v); check("R10 resetting flag", v & 32'h40, 32'h40);
    for (int i = 0; i < RSTC; i++) begin
      if (i == 2) begin bus_wr = 1; bus_addr = 5'd4; bus_wdata = 32'h11; end
      if (i == 3) begin bus_wr = 0; done_irq_en = 1; err_irq_mask = 8'hFF; err_code = 8'h1;
                        done_evt = 1; err_evt = 1; end
      if (i == 4) begin done_evt = 0; err_evt = 0; done_irq_en = 0; end
      check($sformatf("R10 high cycle %0d", i), {30'd0, eng_reset, fifo_flush}, 32'd2);
      @(negedge clk);
    end
    check("R10 ended, R11 flush", {30'd0, eng_reset, fifo_flush}, 32'd1);
    rd(1, v); check("R11 ctl cleared", v, 32'h0);
    rd(0, v); check("R11 R12 sticky clear", v, 32'h0000000A);
    @(negedge clk);
    check("R11 flush one cycle", {31'd0, fifo_flush}, 32'd0);
    rd(0, v); check("R12 no late event", v, 32'h0000000A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_readmap();
    t_live_bits();
    t_done_irq();
    t_err_mask();
    t_stop_err();
    t_stop_early();
    t_ctl_bits();
    t_reset_seq();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule